// File: doc/BRIEF.md
# Bus Break Condition Comparator

This block watches a single bus-cycle channel and requests a debug break when a programmed condition matches. Each cycle carries an address, a data word, an operand size (byte, word or longword), a cycle type (instruction fetch or data access) and the bus master that issued it (CPU or DMA). A small write-only register interface holds the break address, an address mask, the break data, a data mask and a control word. The control word holds the expected size or "any size", the cycle type, the bus master and a data-compare enable.

The number of address bits compared follows the size of the access on the bus. A longword access matches anywhere inside its aligned four bytes. A word access matches anywhere inside its aligned two bytes. A byte access must match exactly. When data comparison is on, byte data is taken from the lane chosen by address bit 0 and compared against the low byte of the break data. Word data uses the low halfword and longword data uses all 32 bits.

A match produces a one-cycle break pulse, registered on the clock edge that samples the bus cycle. It also sets a sticky flag, which software clears by writing one.

Top module: `brk_cmp_top`

## Requirements
- R1: After a synchronous reset, `brk_pulse` and `brk_sticky` are 0 and all configuration registers are 0 (channel disabled).
- R2: The size on the bus sets how many address bits are compared: size 2 (longword) ignores address bits 1..0, size 1 (word) ignores bit 0, and size 0 (byte) compares every bit. With break address 0x00001003 and any size allowed, a longword at 0x00001000, a word at 0x00001002 and a byte at 0x00001003 all match.
- R3: An address bit whose address-mask register bit (register index 1) is 1 takes no part in the address comparison.
- R4: Control bits 2..1 select the size: 0 byte, 1 word, 2 longword, 3 any size. A cycle of another size than the selected one never matches.
- R5: Control bits 4..3 select the cycle type (0 fetch only, 1 data only, 2 or 3 either). Control bits 6..5 select the master (0 CPU only, 1 DMA only, 2 or 3 either). `bus_fetch`=1 marks a fetch and `bus_dma`=1 marks a DMA cycle.
- R6: With control bit 7 set, a data cycle matches only if the address condition and the masked data condition both hold. A data-mask bit of 1 (register index 3) excludes that data bit. Byte data is bits 15..8 when address bit 0 is 1 and bits 7..0 otherwise, compared with break data bits 7..0. Word data is bits 15..0. Bits 31..16 of data, break data and mask take no part for byte or word cycles.
- R7: An instruction fetch cycle is never subject to data comparison, even with control bit 7 set.
- R8: A DMA data cycle of longword size never matches while data comparison is enabled.
- R9: With control bit 0 (channel enable) at 0, no cycle matches.
- R10: `brk_pulse` is 1 for exactly the one cycle after a matching cycle sampled with `bus_valid`=1. A cycle with `bus_valid`=0 never matches.
- R11: `brk_sticky` becomes 1 with each break pulse and holds. Writing a value with bit 0 set to register index 5 clears it. A match in the same cycle as the clear wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 3 | Register index: 0 address, 1 address mask, 2 data, 3 data mask, 4 control, 5 clear |
| cfg_wdata | input | 32 | Register write data |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data, aligned to the low lanes |
| bus_size | input | 2 | Operand size: 0 byte, 1 word, 2 longword |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU |
| brk_pulse | output | 1 | One-cycle break request |
| brk_sticky | output | 1 | Sticky match flag |

## Verification
The checker assumes that `bus_size` never carries the reserved code 3 and that register writes and bus cycles are driven synchronously to `clk`. The bench respects both: it drives sizes 0 to 2 only and changes every input at the falling edge. It sweeps size selects against bus sizes and address offsets, data lanes and masks, and every type and master select. Each expected pulse is computed by an arithmetic model written from the requirements.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_ANY  = 2'd3
  } size_e;

  typedef struct packed {
    logic       dcmp;
    logic [1:0] msel;
    logic [1:0] tsel;
    logic [1:0] ssel;
    logic       en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] IDX_BADDR = 3'd0;
  localparam logic [2:0] IDX_AMASK = 3'd1;
  localparam logic [2:0] IDX_BDATA = 3'd2;
  localparam logic [2:0] IDX_DMASK = 3'd3;
  localparam logic [2:0] IDX_CTRL  = 3'd4;
  localparam logic [2:0] IDX_CLR   = 3'd5;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [DW-1:0] cfg_wdata,
  output logic [AW-1:0] baddr,
  output logic [AW-1:0] amask,
  output logic [DW-1:0] bdata,
  output logic [DW-1:0] dmask,
  output ctrl_t         ctl,
  output logic          clr_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      baddr <= '0;
      amask <= '0;
      bdata <= '0;
      dmask <= '0;
      ctl   <= '0;
    end else if (cfg_we) begin
      case (cfg_idx)
        IDX_BADDR: baddr <= cfg_wdata[AW-1:0];
        IDX_AMASK: amask <= cfg_wdata[AW-1:0];
        IDX_BDATA: bdata <= cfg_wdata;
        IDX_DMASK: dmask <= cfg_wdata;
        IDX_CTRL:  ctl   <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  assign clr_req = cfg_we && (cfg_idx == IDX_CLR) && cfg_wdata[0];
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] baddr,
  input  logic [AW-1:0] amask,
  input  logic [1:0]    ssel,
  output logic          addr_ok,
  output logic          size_ok
);
  localparam int unsigned LOW = 2;

  logic [AW-1:0] keep;
  logic [AW-1:0] diff;

  genvar g;
  generate
    for (g = 0; g < AW; g++) begin : g_keep
      if (g >= LOW) begin : g_hi
        assign keep[g] = 1'b1;
      end else if (g == 1) begin : g_b1
        assign keep[g] = (bus_size != SZ_LONG);
      end else begin : g_b0
        assign keep[g] = (bus_size == SZ_BYTE);
      end
    end
  endgenerate

  assign diff    = (bus_addr ^ baddr) & ~amask & keep;
  assign addr_ok = (diff == '0);
  assign size_ok = (ssel == SZ_ANY) || (ssel == bus_size);
endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
  import brk_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] bus_data,
  input  logic          lane_hi,
  input  logic [1:0]    bus_size,
  input  logic [DW-1:0] bdata,
  input  logic [DW-1:0] dmask,
  output logic          data_ok
);
  localparam int unsigned BW = 8;
  localparam int unsigned HW = 2 * BW;

  logic [BW-1:0] lane;
  logic          byte_ok;
  logic          half_ok;
  logic          full_ok;

  assign lane    = lane_hi ? bus_data[HW-1:BW] : bus_data[BW-1:0];
  assign byte_ok = ((lane ^ bdata[BW-1:0]) & ~dmask[BW-1:0]) == '0;
  assign half_ok = ((bus_data[HW-1:0] ^ bdata[HW-1:0]) & ~dmask[HW-1:0]) == '0;

  generate
    if (DW > HW) begin : g_wide
      logic [DW-HW-1:0] upper_diff;
      assign upper_diff = (bus_data[DW-1:HW] ^ bdata[DW-1:HW]) & ~dmask[DW-1:HW];
      assign full_ok    = half_ok && (upper_diff == '0);
    end else begin : g_narrow
      assign full_ok = half_ok;
    end
  endgenerate

  always_comb begin
    case (bus_size)
      SZ_BYTE: data_ok = byte_ok;
      SZ_WORD: data_ok = half_ok;
      default: data_ok = full_ok;
    endcase
  end
endmodule

// File: rtl/brk_cmp_top.sv
module brk_cmp_top
  import brk_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [1:0]    bus_size,
  input  logic          bus_fetch,
  input  logic          bus_dma,
  output logic          brk_pulse,
  output logic          brk_sticky
);
  logic [AW-1:0] baddr, amask;
  logic [DW-1:0] bdata, dmask;
  ctrl_t         ctl;
  logic          clr_req;
  logic          ctl_en, ctl_dcmp;
  logic          addr_ok, size_ok, data_ok;
  logic          type_ok, mstr_ok, dact, dma_block, hit;

  brk_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .baddr(baddr), .amask(amask),
    .bdata(bdata), .dmask(dmask), .ctl(ctl), .clr_req(clr_req)
  );

  brk_addr_cmp #(.AW(AW)) u_addr (
    .bus_addr(bus_addr), .bus_size(bus_size), .baddr(baddr),
    .amask(amask), .ssel(ctl.ssel), .addr_ok(addr_ok), .size_ok(size_ok)
  );

  brk_data_cmp #(.DW(DW)) u_data (
    .bus_data(bus_data), .lane_hi(bus_addr[0]), .bus_size(bus_size),
    .bdata(bdata), .dmask(dmask), .data_ok(data_ok)
  );

  assign ctl_en    = ctl.en;
  assign ctl_dcmp  = ctl.dcmp;
  assign type_ok   = ctl.tsel[1] || (ctl.tsel[0] == !bus_fetch);
  assign mstr_ok   = ctl.msel[1] || (ctl.msel[0] == bus_dma);
  assign dact      = ctl.dcmp && !bus_fetch;
  assign dma_block = dact && bus_dma && (bus_size == SZ_LONG);
  assign hit       = bus_valid && ctl.en && addr_ok && size_ok && type_ok
                     && mstr_ok && (!dact || data_ok) && !dma_block;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_pulse  <= 1'b0;
      brk_sticky <= 1'b0;
    end else begin
      brk_pulse <= hit;
      if (hit)          brk_sticky <= 1'b1;
      else if (clr_req) brk_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_valid,
  input logic [1:0] bus_size,
  input logic       bus_fetch,
  input logic       bus_dma,
  input logic       ctl_en,
  input logic       ctl_dcmp,
  input logic       clr_req,
  input logic       brk_pulse,
  input logic       brk_sticky
);
  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> $past(bus_valid)); // R10
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> $past(ctl_en)); // R9
  AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |-> brk_sticky); // R11
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (brk_sticky && !clr_req) |=> brk_sticky); // R11
  AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (brk_sticky == brk_pulse)); // R11
  AST_DMA_LONG_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_dma && !bus_fetch && ctl_dcmp && bus_size == 2'd2)
      |=> !brk_pulse); // R8
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_size != 2'd3)); // R4
endmodule

bind brk_cmp_top brk_cmp_chk u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_size(bus_size),
  .bus_fetch(bus_fetch), .bus_dma(bus_dma), .ctl_en(ctl_en),
  .ctl_dcmp(ctl_dcmp), .clr_req(clr_req), .brk_pulse(brk_pulse),
  .brk_sticky(brk_sticky)
);

// File: tb/brk_cmp_top_bench.sv
module brk_cmp_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_fetch = 1'b0;
  logic        bus_dma = 1'b0;
  logic        brk_pulse, brk_sticky;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_baddr, m_amask, m_bdata, m_dmask;
  logic [7:0]  m_ctl;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_cmp_top u_brk_cmp_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_size(bus_size), .bus_fetch(bus_fetch),
    .bus_dma(bus_dma), .brk_pulse(brk_pulse), .brk_sticky(brk_sticky)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] val);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    case (idx)
      3'd0: m_baddr = val;
      3'd1: m_amask = val;
      3'd2: m_bdata = val;
      3'd3: m_dmask = val;
      3'd4: m_ctl   = val[7:0];
      default: ;
    endcase
  endtask

  function automatic bit model(input logic [31:0] a, input logic [31:0] d,
                               input logic [1:0] sz, input bit f, input bit dm);
    logic [31:0] keep;
    logic [7:0]  ln;
    bit sz_ok, a_ok, t_ok, m_ok, d_ok, dact;
    sz_ok = (m_ctl[2:1] == 2'd3) || (m_ctl[2:1] == sz);
    keep  = (sz == 2'd2) ? 32'hFFFF_FFFC : (sz == 2'd1) ? 32'hFFFF_FFFE : 32'hFFFF_FFFF;
    a_ok  = (((a ^ m_baddr) & ~m_amask & keep) == 0);
    t_ok  = m_ctl[4] || (m_ctl[3] == !f);
    m_ok  = m_ctl[6] || (m_ctl[5] == dm);
    dact  = m_ctl[7] && !f;
    ln    = a[0] ? d[15:8] : d[7:0];
    if (sz == 2'd0)      d_ok = (((ln ^ m_bdata[7:0]) & ~m_dmask[7:0]) == 0);
    else if (sz == 2'd1) d_ok = (((d[15:0] ^ m_bdata[15:0]) & ~m_dmask[15:0]) == 0);
    else                 d_ok = (((d ^ m_bdata) & ~m_dmask) == 0);
    if (dact && dm && sz == 2'd2) return 1'b0;
    return m_ctl[0] && sz_ok && a_ok && t_ok && m_ok && (!dact || d_ok);
  endfunction

  task automatic cyc(input string req, input logic [31:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input bit f, input bit dm);
    bit e;
    e = model(a, d, sz, f, dm);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_size = sz;
    bus_fetch = f; bus_dma = dm;
    @(negedge clk);
    bus_valid = 1'b0;
    check(brk_pulse == e, req, brk_pulse, e);
  endtask

  task automatic cyc_fixed(input string req, input logic [31:0] a, input logic [31:0] d,
                           input logic [1:0] sz, input bit f, input bit dm, input bit e);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_size = sz;
    bus_fetch = f; bus_dma = dm;
    @(negedge clk);
    bus_valid = 1'b0;
    check(brk_pulse == e, req, brk_pulse, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_baddr = 0; m_amask = 0; m_bdata = 0; m_dmask = 0; m_ctl = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(brk_pulse == 0, "R1 pulse", brk_pulse, 0);
    check(brk_sticky == 0, "R1 sticky", brk_sticky, 0);
    cyc("R1 disabled after reset", 32'h0, 32'h0, 2'd0, 1'b0, 1'b0);

    // R2 / R4: size select against size and offset
    wr(3'd0, 32'h0000_1003);
    for (int s = 0; s < 4; s++) begin
      wr(3'd4, 32'h51 | (s << 1));
      for (int o = 0; o < 8; o++)
        for (int z = 0; z < 3; z++)
          cyc("R2 R4 size sweep", 32'h1000 + o, 32'h0, z[1:0], 1'b0, 1'b0);
    end
    wr(3'd4, 32'h57);
    cyc_fixed("R2 long at 0x1000", 32'h1000, 0, 2'd2, 1'b0, 1'b0, 1'b1);
    cyc_fixed("R2 word at 0x1002", 32'h1002, 0, 2'd1, 1'b0, 1'b0, 1'b1);
    cyc_fixed("R2 byte at 0x1003", 32'h1003, 0, 2'd0, 1'b0, 1'b0, 1'b1);
    cyc_fixed("R2 byte at 0x1002", 32'h1002, 0, 2'd0, 1'b0, 1'b0, 1'b0);
    check(brk_pulse == 0, "R10 single cycle", brk_pulse, 0);
    bus_addr = 32'h1003; bus_size = 2'd0;
    @(negedge clk);
    check(brk_pulse == 0, "R10 no valid", brk_pulse, 0);

    // R3: address mask
    wr(3'd1, 32'h0000_F0F0);
    for (int k = 0; k < 16; k++)
      cyc("R3 mask sweep", 32'h1003 ^ (k << 4) ^ ((k & 1) << 8), 0, 2'd0, 1'b0, 1'b0);
    wr(3'd1, 32'h0);

    // R6: data compare, lanes, masks
    wr(3'd0, 32'h0000_2001);
    wr(3'd2, 32'h3C3C_5A5A);
    wr(3'd4, 32'hD7);
    for (int m = 0; m < 2; m++) begin
      wr(3'd3, m ? 32'h0000_0F0F : 32'h0);
      for (int v = 0; v < 6; v++)
        for (int o = 0; o < 4; o++)
          for (int z = 0; z < 3; z++)
            cyc("R6 data sweep", 32'h2000 + o,
                (v == 0) ? 32'h0000_5A5A : (v == 1) ? 32'h1234_5A00 :
                (v == 2) ? 32'h0000_005A : (v == 3) ? 32'hFFFF_5A5A :
                (v == 4) ? 32'h3C3C_5A5A : 32'h0000_5F55,
                z[1:0], 1'b0, 1'b0);
    end
    wr(3'd3, 32'h0);
    cyc_fixed("R6 byte hi lane", 32'h2001, 32'h0000_5A00, 2'd0, 1'b0, 1'b0, 1'b1);
    cyc_fixed("R6 byte hi lane miss", 32'h2001, 32'h0000_005A, 2'd0, 1'b0, 1'b0, 1'b0);
    cyc_fixed("R6 word upper ignored", 32'h2000, 32'hDEAD_5A5A, 2'd1, 1'b0, 1'b0, 1'b1);

    // R5 / R7: type and master selects, fetch skips data
    wr(3'd2, 32'h0);
    for (int t = 0; t < 4; t++)
      for (int q = 0; q < 4; q++) begin
        wr(3'd4, 32'h87 | (t << 3) | (q << 5));
        for (int f = 0; f < 2; f++)
          for (int dm = 0; dm < 2; dm++)
            cyc("R5 R7 type master sweep", 32'h2000, 32'hFFFF_FFFF, 2'd1, f[0], dm[0]);
      end
    wr(3'd4, 32'hD7);
    cyc_fixed("R7 fetch ignores data", 32'h2000, 32'hFFFF_FFFF, 2'd1, 1'b1, 1'b0, 1'b1);

    // R8: DMA longword with data compare
    wr(3'd2, 32'h1111_2222);
    cyc_fixed("R8 dma long blocked", 32'h2000, 32'h1111_2222, 2'd2, 1'b0, 1'b1, 1'b0);
    cyc_fixed("R8 cpu long allowed", 32'h2000, 32'h1111_2222, 2'd2, 1'b0, 1'b0, 1'b1);
    cyc_fixed("R8 dma word allowed", 32'h2000, 32'h1111_2222, 2'd1, 1'b0, 1'b1, 1'b1);

    // R9: enable off
    wr(3'd4, 32'hD6);
    cyc_fixed("R9 disabled", 32'h2000, 32'h1111_2222, 2'd1, 1'b0, 1'b0, 1'b0);
    cyc_fixed("R9 disabled long", 32'h2000, 32'h1111_2222, 2'd2, 1'b0, 1'b0, 1'b0);

    // R11: sticky flag
    wr(3'd5, 32'h1);
    check(brk_sticky == 0, "R11 cleared", brk_sticky, 0);
    wr(3'd4, 32'hD7);
    cyc_fixed("R11 hit", 32'h2000, 32'h1111_2222, 2'd1, 1'b0, 1'b0, 1'b1);
    check(brk_sticky == 1, "R11 set", brk_sticky, 1);
    repeat (3) @(negedge clk);
    check(brk_sticky == 1, "R11 holds", brk_sticky, 1);
    wr(3'd5, 32'h2);
    check(brk_sticky == 1, "R11 bit0 zero no clear", brk_sticky, 1);
    wr(3'd5, 32'h1);
    check(brk_sticky == 0, "R11 write one clears", brk_sticky, 0);
    cfg_we = 1'b1; cfg_idx = 3'd5; cfg_wdata = 32'h1;
    bus_valid = 1'b1; bus_addr = 32'h2000; bus_data = 32'h1111_2222;
    bus_size = 2'd1; bus_fetch = 1'b0; bus_dma = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; bus_valid = 1'b0;
    check(brk_sticky == 1, "R11 set beats clear", brk_sticky, 1);

    // R1: reset again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(brk_sticky == 0 && brk_pulse == 0, "R1 reset clears", brk_sticky, 0);
    m_ctl = 0;
    cyc("R1 config cleared", 32'h2000, 32'h1111_2222, 2'd1, 1'b0, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule